// File: doc/BRIEF.md
# Framed Return-to-Zero Pulse Pattern Generator

This block sends a serial bit pattern on one digital line as a train of short return-to-zero pulses. Time is cut into fixed bit slots of 2 µs, a 500 kHz bit rate. A one bit drives the line high for the first quarter of its slot, which is 0.5 µs, and low for the rest of the slot. A zero bit keeps the line low for the whole slot. A pattern holds 15 to 30 bits and is sent most significant bit first. It repeats inside a fixed frame of 256 slots, which is 512 µs. The line stays low from the end of the pattern until the next frame begins.

Software or a sequencer places a pattern and a length on the inputs and pulses `load`. The values go into a staging register, and the generator copies them into its working register only on a frame boundary. A frame therefore never mixes two patterns, and a `load` can arrive at any time. The `enable` input starts and stops framing. Each start begins with a complete frame from slot 0. A one-cycle `frame_start` strobe marks the first cycle of every frame, and a one-cycle `tx_done` strobe marks the cycle that follows the last bit slot. The slot and pulse lengths in clock cycles come from the clock frequency parameter. At 40 MHz a slot is 80 cycles and a pulse is 20 cycles.

Top module: `rz_pattern_gen`

## Requirements
- R1: A bit slot lasts SLOT = CLK_HZ/BIT_HZ clock cycles. For a one bit, `pulse_out` is high for the first SLOT/4 cycles of the slot and low for the remaining cycles of that slot.
- R2: For a zero bit, `pulse_out` stays low for the whole slot.
- R3: With an effective length L, the first slot of a frame carries `pattern_in[L-1]` and slot L-1 carries `pattern_in[0]`. Pattern bits at L and above have no effect on the line.
- R4: `length_in` is clamped to the range 15 to 30 when it is captured. A value below 15 behaves as 15, and a value above 30 behaves as 30.
- R5: A frame lasts exactly 256 slots (256*SLOT cycles). Frames follow one another with no gap. Once the last bit slot ends, `pulse_out` stays low until the next frame starts.
- R6: `frame_start` is high for exactly one cycle. That cycle is the first cycle of slot 0 of every frame.
- R7: `tx_done` is high for exactly one cycle. That cycle is the first cycle of slot L, the slot right after the final bit, and the line is low in it.
- R8: A `load` captures the pattern and length at any time. The captured values take effect at the next frame start. The frame in progress is unchanged by the load, and when no new load arrives the same pattern repeats.
- R9: While `enable` is low, every output goes low within two cycles and framing stops. When `enable` rises, `frame_start` and the first slot of a complete frame appear two clock edges after `enable` is first sampled high. The first frame uses the pattern staged before the start.
- R10: During reset and after reset, with `enable` low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs framing while high |
| load | input | 1 | Captures pattern and length into staging |
| pattern_in | input | MAX_BITS | Pattern bits; bit L-1 is sent first |
| length_in | input | $clog2(MAX_BITS+1) | Requested pattern length in bits |
| pulse_out | output | 1 | Return-to-zero pulse line |
| frame_start | output | 1 | One-cycle strobe at the first cycle of a frame |
| tx_done | output | 1 | One-cycle strobe after the last bit slot |

## Verification
All three outputs are registered one cycle after the slot and cycle counters. The first frame cycle therefore appears on the ports two rising edges after `enable` is first sampled high. A `load` sampled on one edge can only affect the frame that starts after the current frame ends. The bench drives inputs and samples outputs on falling edges. After raising `enable` it waits two falling edges, and then it compares every cycle of each frame against a frame-relative cycle index i. With i, the bench computes the expected line value from the slot index i/SLOT and the phase i%SLOT. It expects `frame_start` at i=0 and `tx_done` at i=L*SLOT. Each new pattern is loaded a few cycles into a frame, so that a design taking the load early corrupts the frame in progress. After `enable` drops, the bench allows two cycles before it expects the line to be quiet.

// File: rtl/rzpg_pkg.sv
package rzpg_pkg;

  // Clock cycles in one bit slot.
  function automatic int slot_cycles(input int clk_hz, input int bit_hz);
    return clk_hz / bit_hz;
  endfunction

  // High time of a one bit: a quarter of the slot, never less than one cycle.
  function automatic int high_cycles(input int slot);
    return (slot / 4 < 1) ? 1 : slot / 4;
  endfunction

  // Requested length forced into the legal range.
  function automatic int clamp_len(input int raw, input int lo, input int hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

endpackage

// File: rtl/rzpg_timebase.sv
module rzpg_timebase #(
  parameter int SLOT_CYC    = 80,
  parameter int FRAME_SLOTS = 256,
  parameter int CYC_W       = 7,
  parameter int SLOT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic              running,
  output logic [CYC_W-1:0]  cyc,
  output logic [SLOT_W-1:0] slot,
  output logic              take_frame
);

  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_CYC - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(FRAME_SLOTS - 1);

  logic slot_end;
  logic frame_end;

  assign slot_end  = (cyc == CYC_LAST);
  assign frame_end = slot_end && (slot == SLOT_LAST);

  // High on the edge whose result is cycle 0 of slot 0.
  assign take_frame = enable && (!running || frame_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cyc     <= '0;
      slot    <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      cyc     <= '0;
      slot    <= '0;
    end else if (!running) begin
      running <= 1'b1;
      cyc     <= '0;
      slot    <= '0;
    end else if (slot_end) begin
      cyc  <= '0;
      slot <= frame_end ? '0 : slot + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

endmodule

// File: rtl/rzpg_pattern_store.sv
module rzpg_pattern_store #(
  parameter int MIN_BITS = 15,
  parameter int MAX_BITS = 30,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] pattern_in,
  input  logic [LEN_W-1:0]    length_in,
  input  logic                take_frame,
  output logic [MAX_BITS-1:0] act_pat,
  output logic [LEN_W-1:0]    act_len
);

  localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(MIN_BITS);

  logic [MAX_BITS-1:0] stage_pat;
  logic [LEN_W-1:0]    stage_len;
  logic [LEN_W-1:0]    len_clamped;

  assign len_clamped = LEN_W'(rzpg_pkg::clamp_len(int'(length_in), MIN_BITS, MAX_BITS));

  // Staging side: written whenever load is seen.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_pat <= '0;
      stage_len <= LEN_RST;
    end else if (load) begin
      stage_pat <= pattern_in;
      stage_len <= len_clamped;
    end
  end

  // Working side: written only on a frame boundary.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pat <= '0;
      act_len <= LEN_RST;
    end else if (take_frame) begin
      act_pat <= stage_pat;
      act_len <= stage_len;
    end
  end

endmodule

// File: rtl/rzpg_slot_shaper.sv
module rzpg_slot_shaper #(
  parameter int HIGH_CYC = 20,
  parameter int MAX_BITS = 30,
  parameter int LEN_W    = 5,
  parameter int CYC_W    = 7,
  parameter int SLOT_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                running,
  input  logic [CYC_W-1:0]    cyc,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [MAX_BITS-1:0] act_pat,
  input  logic [LEN_W-1:0]    act_len,
  output logic                pulse_out,
  output logic                frame_start,
  output logic                tx_done
);

  localparam logic [CYC_W-1:0] HIGH_LIM = CYC_W'(HIGH_CYC);

  logic [31:0]      slot_x;
  logic [31:0]      len_x;
  logic [LEN_W-1:0] bit_idx;
  logic             in_bits;
  logic             in_high;
  logic             slot_head;
  logic             pulse_d;
  logic             start_d;
  logic             done_d;

  assign slot_x    = 32'(slot);
  assign len_x     = 32'(act_len);
  assign in_bits   = (slot_x < len_x);
  assign slot_head = (cyc == '0);
  // Most significant bit of the pattern goes out in slot 0.
  assign bit_idx   = act_len - LEN_W'(1) - LEN_W'(slot);

  generate
    if (HIGH_CYC == 1) begin : g_high_one
      assign in_high = slot_head;
    end else begin : g_high_many
      assign in_high = (cyc < HIGH_LIM);
    end
  endgenerate

  assign pulse_d = running && in_bits && in_high && act_pat[bit_idx];
  assign start_d = running && (slot == '0) && slot_head;
  assign done_d  = running && (slot_x == len_x) && slot_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_out   <= 1'b0;
      frame_start <= 1'b0;
      tx_done     <= 1'b0;
    end else begin
      pulse_out   <= pulse_d;
      frame_start <= start_d;
      tx_done     <= done_d;
    end
  end

endmodule

// File: rtl/rz_pattern_gen.sv
module rz_pattern_gen #(
  parameter int CLK_HZ      = 40_000_000,
  parameter int BIT_HZ      = 500_000,
  parameter int FRAME_SLOTS = 256,
  parameter int MIN_BITS    = 15,
  parameter int MAX_BITS    = 30,
  localparam int LEN_W      = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                load,
  input  logic [MAX_BITS-1:0] pattern_in,
  input  logic [LEN_W-1:0]    length_in,
  output logic                pulse_out,
  output logic                frame_start,
  output logic                tx_done
);

  localparam int SLOT_CYC = rzpg_pkg::slot_cycles(CLK_HZ, BIT_HZ);
  localparam int HIGH_CYC = rzpg_pkg::high_cycles(SLOT_CYC);
  localparam int CYC_W    = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
  localparam int SLOT_W   = $clog2(FRAME_SLOTS);

  logic                running;
  logic [CYC_W-1:0]    cyc;
  logic [SLOT_W-1:0]   slot;
  logic                take_frame;
  logic [MAX_BITS-1:0] act_pat;
  logic [LEN_W-1:0]    act_len;

  rzpg_timebase #(
    .SLOT_CYC   (SLOT_CYC),
    .FRAME_SLOTS(FRAME_SLOTS),
    .CYC_W      (CYC_W),
    .SLOT_W     (SLOT_W)
  ) u_time (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .running   (running),
    .cyc       (cyc),
    .slot      (slot),
    .take_frame(take_frame)
  );

  rzpg_pattern_store #(
    .MIN_BITS(MIN_BITS),
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .pattern_in(pattern_in),
    .length_in (length_in),
    .take_frame(take_frame),
    .act_pat   (act_pat),
    .act_len   (act_len)
  );

  rzpg_slot_shaper #(
    .HIGH_CYC(HIGH_CYC),
    .MAX_BITS(MAX_BITS),
    .LEN_W   (LEN_W),
    .CYC_W   (CYC_W),
    .SLOT_W  (SLOT_W)
  ) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .cyc        (cyc),
    .slot       (slot),
    .act_pat    (act_pat),
    .act_len    (act_len),
    .pulse_out  (pulse_out),
    .frame_start(frame_start),
    .tx_done    (tx_done)
  );

endmodule

// File: rtl/rz_pattern_gen_chk.sv
module rz_pattern_gen_chk #(
  parameter int HIGH_CYC = 20,
  parameter int PAT_W    = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             pulse_out,
  input logic             frame_start,
  input logic             tx_done,
  input logic             take_frame,
  input logic [PAT_W-1:0] act_pat
);

  // Count of consecutive high cycles before the current one.
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n)         hi_run <= '0;
    else if (pulse_out) hi_run <= hi_run + 16'd1;
    else                hi_run <= '0;
  end

  // R1: a pulse is never longer than the high time
  a_r1_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (32'(hi_run) < HIGH_CYC));

  // R6: frame start lasts one cycle
  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R6: frame start comes two edges after the boundary decision
  a_r6_start_from_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(take_frame, 2));

  // R7: done strobe lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R7 and R5: the line is low when the done strobe is high
  a_r7_done_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !pulse_out);

  // R8: the working pattern changes only at a frame boundary
  a_r8_pattern_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !take_frame |=> $stable(act_pat));

  // R9: with enable held low, all outputs are quiet
  a_r9_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |=> (!pulse_out && !frame_start && !tx_done));

endmodule

bind rz_pattern_gen rz_pattern_gen_chk #(
  .HIGH_CYC(HIGH_CYC),
  .PAT_W   (MAX_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .pulse_out  (pulse_out),
  .frame_start(frame_start),
  .tx_done    (tx_done),
  .take_frame (take_frame),
  .act_pat    (act_pat)
);

// File: tb/tb_rz_pattern_gen.sv
module tb_rz_pattern_gen;

  localparam int CLK_HZ  = 2_000_000;
  localparam int BIT_HZ  = 500_000;
  localparam int NSLOTS  = 256;
  localparam int LO      = 15;
  localparam int HI      = 30;
  localparam int SLOT    = CLK_HZ / BIT_HZ;
  localparam int HIGH    = SLOT >> 2;
  localparam int FRAME   = NSLOTS * SLOT;
  localparam int LOAD_AT = 10;
  localparam int NCASE   = 51;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        load;
  logic [29:0] pattern_in;
  logic [4:0]  length_in;
  logic        pulse_out;
  logic        frame_start;
  logic        tx_done;

  int n_tests = 0;
  int n_fail  = 0;

  logic [29:0] pats [NCASE];
  int          raws [NCASE];

  rz_pattern_gen #(
    .CLK_HZ     (CLK_HZ),
    .BIT_HZ     (BIT_HZ),
    .FRAME_SLOTS(NSLOTS),
    .MIN_BITS   (LO),
    .MAX_BITS   (HI)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .load       (load),
    .pattern_in (pattern_in),
    .length_in  (length_in),
    .pulse_out  (pulse_out),
    .frame_start(frame_start),
    .tx_done    (tx_done)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R5 watchdog: actual=still running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic int eff_len(input int raw);
    return (raw < LO) ? LO : (raw > HI) ? HI : raw;
  endfunction

  function automatic logic [2:0] expect_at(input logic [29:0] p, input int len, input int i);
    int s  = i / SLOT;
    int ph = i % SLOT;
    logic pl = (s < len) && (ph < HIGH) && p[len - 1 - s];
    return {pl, (i == 0), (i == len * SLOT)};
  endfunction

  task automatic check_quiet(input int cycles, input string req);
    int bad = 0;
    for (int c = 0; c < cycles; c++) begin
      if ({pulse_out, frame_start, tx_done} !== 3'b000) bad++;
      @(negedge clk);
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: actual=%0d active cycles expected=0", req, bad);
    end
  endtask

  // Checks one whole frame; optionally stages the next pattern mid-frame.
  task automatic run_frame(input logic [29:0] p, input int raw, input string req,
                           input bit do_load, input logic [29:0] np, input int nraw);
    int len = eff_len(raw);
    int bad = 0;
    int at  = 0;
    logic [2:0] got = '0;
    logic [2:0] want = '0;
    for (int i = 0; i < FRAME; i++) begin
      logic [2:0] e = expect_at(p, len, i);
      logic [2:0] a = {pulse_out, frame_start, tx_done};
      if (a !== e) begin
        if (bad == 0) begin
          at = i; got = a; want = e;
        end
        bad++;
      end
      if (do_load && i == LOAD_AT) begin
        load       = 1'b1;
        pattern_in = np;
        length_in  = 5'(nraw);
      end
      if (i == LOAD_AT + 1) load = 1'b0;
      @(negedge clk);
    end
    n_tests++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: L=%0d cycle %0d pulse/start/done actual=%b expected=%b (%0d bad cycles)",
               req, len, at, got, want, bad);
    end
  endtask

  initial begin
    for (int k = 0; k < 48; k++) begin
      raws[k] = LO + (k % 16);
      case (k / 16)
        0:       pats[k] = 30'h3FFF_FFFF;
        1:       pats[k] = 30'h2AAA_AAAA;
        default: pats[k] = 30'((k * 32'h9E37_79B1) ^ 32'h5BD1_E995);
      endcase
    end
    pats[48] = 30'h1234_5678; raws[48] = 3;
    pats[49] = 30'h0F0F_3C3C; raws[49] = 0;
    pats[50] = 30'h3C96_A5E1; raws[50] = 31;

    rst_n = 1'b0; enable = 1'b0; load = 1'b0;
    pattern_in = '0; length_in = 5'd15;
    repeat (2) @(negedge clk);
    check_quiet(4, "R10 in reset");
    rst_n = 1'b1;
    check_quiet(6, "R10 idle after reset");

    // Stage the first pattern, then start framing.
    load = 1'b1; pattern_in = pats[0]; length_in = 5'(raws[0]);
    @(negedge clk);
    load = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Sweep: R1 R2 R3 R5 R6 R7 on each length and pattern kind; R8 by mid-frame loads.
    for (int k = 0; k < NCASE; k++) begin
      if (k < NCASE - 1)
        run_frame(pats[k], raws[k], (k >= 48) ? "R4 clamp" : "R3 sweep",
                  1'b1, pats[k+1], raws[k+1]);
      else
        run_frame(pats[k], raws[k], "R4 clamp", 1'b0, '0, 0);
    end
    // No new load: the same pattern repeats (R8, R5).
    run_frame(pats[NCASE-1], raws[NCASE-1], "R8 repeat", 1'b0, '0, 0);

    // Stop, stage while stopped, restart (R9).
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_quiet(40, "R9 disabled");
    load = 1'b1; pattern_in = 30'h2D4C_3B19; length_in = 5'd22;
    @(negedge clk);
    load = 1'b0;
    check_quiet(5, "R9 staged while off");
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run_frame(30'h2D4C_3B19, 22, "R9 first frame", 1'b0, '0, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule